// File: doc/BRIEF.md
# Proxy Command Response Tracker

This block sits behind a byte-level SMBus target and carries one proxied sideband command from the moment its block-write packet arrives until the result is read back. When the last byte of a packet arrives, the block checks the opcode and the parameter count. A small local command is answered on the spot. A malformed command is answered with an error on the spot. A well-formed remote command is handed to an internal responder over a valid/ready request port, and the responder later returns a completion strobe that carries an error flag, an error code and read-back data.

The host polls with SMBus block reads. The read engine asks for a byte index and gets back one response byte and the current byte count. The count alone tells the host the outcome: one byte means the command is still running, two bytes mean it failed or that nothing has been issued, and more than two bytes mean it succeeded. Only one command may be outstanding. A dedicated clear command drops all pending state, and any completion that belongs to a request cut off this way is thrown away when it arrives.

Top module: `proxy_tracker`

## Requirements
- R1: Response byte 0 is the status byte. Bit 0 is the busy flag, bit 1 is the error flag, and bits 7..2 always read zero. Any index at or beyond the byte count reads 0x00.
- R2: From the clock edge that takes the last byte of a forwarded command until its completion is taken, the count is 1 and the status byte is 0x01.
- R3: A failed command reads with count 2, status 0x02 and the error code at index 1. A responder completion with the error flag set gives its own error code there.
- R4: A successful completion of length L gives the data length D = max(min(L, MAX_DATA), 2) and a count of 1 + D. Status is 0x00. Index k (1..D) holds completion byte k-1, where byte j sits at bits 8j+7..8j. Indices past min(L, MAX_DATA) read zero.
- R5: Opcodes are 0x01 (local ping, 0 parameters), 0x02 (remote read, 2 parameters), 0x03 (remote write, 3 parameters) and 0x0F (clear). Checks take effect at the edge that takes the last byte. An unknown opcode gives error code 0x01, a wrong parameter count gives error code 0x02, and a ping gives success with two zero data bytes.
- R6: After a valid remote command, reqValid rises in the next cycle and stays high until reqReady is sampled high. reqOp carries the opcode, and reqParam carries parameter i at bits 8i+7..8i, with unused bytes zero. A completion counts only after that handshake.
- R7: A non-clear packet that ends while a command is outstanding is dropped. The request port and the busy response stay unchanged.
- R8: A clear packet (opcode 0x0F, any number of parameters) ends any pending command at once, even mid-request, and withdraws an unaccepted request.
- R9: Each request that was already accepted, or accepted in the same cycle, when a clear arrives has its later completion discarded. A completion with no request waiting is ignored.
- R10: After system reset and after a clear, the response is count 2, status 0x02, error code 0x00.
- R11: A packet is the run of wrValid bytes up to and including the one with wrLast. Its first byte is the opcode. Idle cycles between bytes do not split a packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrValid | input | 1 | Write byte strobe |
| wrByte | input | 8 | Write byte |
| wrLast | input | 1 | Marks the final byte of a packet |
| reqValid | output | 1 | Request to the responder |
| reqReady | input | 1 | Responder accepts the request |
| reqOp | output | 8 | Forwarded opcode |
| reqParam | output | MAX_PARAM*8 | Forwarded parameters, byte i at bits 8i+7..8i |
| cplValid | input | 1 | Completion strobe |
| cplErr | input | 1 | Completion reports a failure |
| cplCode | input | 8 | Failure code |
| cplLen | input | $clog2(MAX_DATA+2) | Number of read-back bytes |
| cplData | input | MAX_DATA*8 | Read-back bytes, byte j at bits 8j+7..8j |
| rdIdx | input | $clog2(MAX_DATA+2) | Response byte index |
| rdByte | output | 8 | Response byte at rdIdx |
| rspCount | output | $clog2(MAX_DATA+2) | Response byte count |

## Verification
The bench builds the block with MAX_PARAM = 4 and MAX_DATA = 8. With four parameter slots, a packet that overruns the buffer can be driven, and it must still report a bad length. With eight data slots, the bench can reach the full nine-byte success response, a responder length of twelve that gets capped, and zero-length write completions that get padded. The bench also times clear packets against every request phase, so that both orphaned and withdrawn requests are exercised.

// File: rtl/ptrk_pkg.sv
package ptrk_pkg;
  localparam logic [7:0] OP_PING  = 8'h01;
  localparam logic [7:0] OP_READ  = 8'h02;
  localparam logic [7:0] OP_WRITE = 8'h03;
  localparam logic [7:0] OP_CLEAR = 8'h0F;
  localparam int READ_PARAMS  = 2;
  localparam int WRITE_PARAMS = 3;
  localparam logic [7:0] CODE_NONE   = 8'h00;
  localparam logic [7:0] CODE_BADOP  = 8'h01;
  localparam logic [7:0] CODE_BADLEN = 8'h02;

  typedef enum logic [2:0] {PK_CLEAR, PK_PING, PK_FWD, PK_BADOP, PK_BADLEN} pktKind_e;
  typedef enum logic [1:0] {RS_NONE, RS_BUSY, RS_ERR, RS_OK} rspKind_e;
  typedef enum logic [1:0] {PH_IDLE, PH_REQ, PH_WAIT} phase_e;

  typedef struct packed {
    logic       latchReq;
    logic       markBusy;
    logic       markErr;
    logic [7:0] errCode;
    logic       markPing;
    logic       markCpl;
    logic       markNone;
  } ctrlStrobe_t;
endpackage

// File: rtl/ptrk_datapath.sv
module ptrk_datapath
  import ptrk_pkg::*;
#(
  parameter int MAX_PARAM = 4,
  parameter int MAX_DATA  = 8,
  parameter int CNT_W     = $clog2(MAX_DATA + 2)
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    wrValid,
  input  logic [7:0]              wrByte,
  input  logic                    wrLast,
  output logic                    pktEnd,
  output pktKind_e                pktKind,
  input  ctrlStrobe_t             str,
  input  logic                    cplErr,
  input  logic [7:0]              cplCode,
  input  logic [CNT_W-1:0]        cplLen,
  input  logic [MAX_DATA*8-1:0]   cplData,
  output logic [7:0]              reqOp,
  output logic [MAX_PARAM*8-1:0]  reqParam,
  input  logic [CNT_W-1:0]        rdIdx,
  output logic [7:0]              rdByte,
  output logic [CNT_W-1:0]        rspCount
);
  localparam int PCNT_W = $clog2(MAX_PARAM + 2);
  localparam logic [PCNT_W-1:0] PCNT_SAT = PCNT_W'(MAX_PARAM + 1);

  logic                          inPkt;
  logic [7:0]                    opReg;
  logic [PCNT_W-1:0]             paramCnt;
  logic [MAX_PARAM-1:0][7:0]     paramBuf;
  logic [7:0]                    finalOp;
  logic [PCNT_W-1:0]             finalCnt;
  logic [MAX_PARAM-1:0][7:0]     bufNext;

  rspKind_e                      rspKind;
  logic [7:0]                    rspCode;
  logic [MAX_DATA-1:0][7:0]      rspData;
  logic [CNT_W-1:0]              rspLen;
  logic [CNT_W-1:0]              capLen;

  // packet assembly
  always_comb begin
    finalOp  = inPkt ? opReg : wrByte;
    finalCnt = '0;
    if (inPkt) finalCnt = (paramCnt == PCNT_SAT) ? paramCnt : paramCnt + PCNT_W'(1);
    bufNext = inPkt ? paramBuf : '0;
    for (int i = 0; i < MAX_PARAM; i++)
      if (wrValid && inPkt && paramCnt == PCNT_W'(i)) bufNext[i] = wrByte;
  end

  assign pktEnd = wrValid && wrLast;

  always_comb begin
    case (finalOp)
      OP_CLEAR: pktKind = PK_CLEAR;
      OP_PING:  pktKind = (finalCnt == '0) ? PK_PING : PK_BADLEN;
      OP_READ:  pktKind = (finalCnt == PCNT_W'(READ_PARAMS)) ? PK_FWD : PK_BADLEN;
      OP_WRITE: pktKind = (finalCnt == PCNT_W'(WRITE_PARAMS)) ? PK_FWD : PK_BADLEN;
      default:  pktKind = PK_BADOP;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      inPkt <= 1'b0; opReg <= '0; paramCnt <= '0; paramBuf <= '0;
    end else if (wrValid) begin
      if (wrLast) begin
        inPkt <= 1'b0; paramCnt <= '0; paramBuf <= '0;
      end else begin
        inPkt <= 1'b1; opReg <= finalOp; paramCnt <= finalCnt; paramBuf <= bufNext;
      end
    end
  end

  // forwarded request registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      reqOp <= '0; reqParam <= '0;
    end else if (str.latchReq) begin
      reqOp <= finalOp; reqParam <= bufNext;
    end
  end

  // response registers
  assign capLen = (cplLen > CNT_W'(MAX_DATA)) ? CNT_W'(MAX_DATA) : cplLen;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspKind <= RS_NONE; rspCode <= CODE_NONE; rspData <= '0; rspLen <= CNT_W'(2);
    end else if (str.markNone) begin
      rspKind <= RS_NONE; rspCode <= CODE_NONE;
    end else if (str.markErr) begin
      rspKind <= RS_ERR; rspCode <= str.errCode;
    end else if (str.markPing) begin
      rspKind <= RS_OK; rspData <= '0; rspLen <= CNT_W'(2);
    end else if (str.markBusy) begin
      rspKind <= RS_BUSY;
    end else if (str.markCpl) begin
      if (cplErr) begin
        rspKind <= RS_ERR; rspCode <= cplCode;
      end else begin
        rspKind <= RS_OK;
        rspLen  <= (capLen < CNT_W'(2)) ? CNT_W'(2) : capLen;
        for (int i = 0; i < MAX_DATA; i++)
          rspData[i] <= (CNT_W'(i) < capLen) ? cplData[8*i +: 8] : 8'h00;
      end
    end
  end

  // read mux
  always_comb begin
    case (rspKind)
      RS_BUSY: rspCount = CNT_W'(1);
      RS_OK:   rspCount = CNT_W'(1) + rspLen;
      default: rspCount = CNT_W'(2);
    endcase
  end

  always_comb begin
    rdByte = 8'h00;
    if (rdIdx < rspCount) begin
      if (rdIdx == '0) begin
        case (rspKind)
          RS_BUSY: rdByte = 8'h01;
          RS_OK:   rdByte = 8'h00;
          default: rdByte = 8'h02;
        endcase
      end else if (rspKind == RS_OK) begin
        for (int i = 0; i < MAX_DATA; i++)
          if (rdIdx == CNT_W'(i + 1)) rdByte = rspData[i];
      end else begin
        rdByte = rspCode;
      end
    end
  end

  assert_status_bits_R1: assert property (@(posedge clk) disable iff (!rstN)
    (rdIdx == '0) |-> (rdByte[7:2] == 6'b0));
  assert_ok_count_R4: assert property (@(posedge clk) disable iff (!rstN)
    (rspKind == RS_OK) |-> (rspCount > CNT_W'(2)));
  assert_clear_R10: assert property (@(posedge clk) disable iff (!rstN)
    str.markNone |=> (rspCount == CNT_W'(2) && rspCode == CODE_NONE));
  assert_drop_R7: assert property (@(posedge clk) disable iff (!rstN)
    (rspKind == RS_BUSY && pktEnd && pktKind != PK_CLEAR) |=> ($stable(reqOp) && $stable(reqParam)));
endmodule

// File: rtl/ptrk_ctrl.sv
module ptrk_ctrl
  import ptrk_pkg::*;
#(
  parameter int STALE_W = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        pktEnd,
  input  pktKind_e    pktKind,
  input  logic        reqReady,
  input  logic        cplValid,
  output logic        reqValid,
  output ctrlStrobe_t str
);
  phase_e              phase, phaseNext;
  logic [STALE_W-1:0]  staleCnt, staleNext;
  logic                curCpl, staleCpl, clearCmd, orphanNew;

  always_comb begin
    str       = '0;
    phaseNext = phase;
    staleNext = staleCnt;
    curCpl    = cplValid && staleCnt == '0 && phase == PH_WAIT;
    staleCpl  = cplValid && staleCnt != '0;
    clearCmd  = pktEnd && pktKind == PK_CLEAR;
    orphanNew = (phase == PH_WAIT && !curCpl) || (phase == PH_REQ && reqReady);
    if (staleCpl) staleNext = staleNext - STALE_W'(1);
    if (clearCmd) begin
      str.markNone = 1'b1;
      phaseNext    = PH_IDLE;
      if (orphanNew && staleNext != '1) staleNext = staleNext + STALE_W'(1);
    end else begin
      case (phase)
        PH_REQ:  if (reqReady) phaseNext = PH_WAIT;
        PH_WAIT: if (curCpl) begin
          str.markCpl = 1'b1;
          phaseNext   = PH_IDLE;
        end
        default: if (pktEnd) begin
          case (pktKind)
            PK_BADOP:  begin str.markErr = 1'b1; str.errCode = CODE_BADOP; end
            PK_BADLEN: begin str.markErr = 1'b1; str.errCode = CODE_BADLEN; end
            PK_PING:   str.markPing = 1'b1;
            PK_FWD:    begin str.latchReq = 1'b1; str.markBusy = 1'b1; phaseNext = PH_REQ; end
            default:   ;
          endcase
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase <= PH_IDLE; staleCnt <= '0;
    end else begin
      phase <= phaseNext; staleCnt <= staleNext;
    end
  end

  assign reqValid = (phase == PH_REQ);

  assert_req_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_REQ && !reqReady && !clearCmd) |=> reqValid);
  assert_stale_drop_R9: assert property (@(posedge clk) disable iff (!rstN)
    (cplValid && staleCnt != '0) |-> !str.markCpl);
  assert_single_update_R7: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({str.markNone, str.markErr, str.markPing, str.markBusy, str.markCpl}));
endmodule

// File: rtl/proxy_tracker.sv
module proxy_tracker
  import ptrk_pkg::*;
#(
  parameter int MAX_PARAM = 4,
  parameter int MAX_DATA  = 8,
  localparam int CNT_W    = $clog2(MAX_DATA + 2)
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   wrValid,
  input  logic [7:0]             wrByte,
  input  logic                   wrLast,
  output logic                   reqValid,
  input  logic                   reqReady,
  output logic [7:0]             reqOp,
  output logic [MAX_PARAM*8-1:0] reqParam,
  input  logic                   cplValid,
  input  logic                   cplErr,
  input  logic [7:0]             cplCode,
  input  logic [CNT_W-1:0]       cplLen,
  input  logic [MAX_DATA*8-1:0]  cplData,
  input  logic [CNT_W-1:0]       rdIdx,
  output logic [7:0]             rdByte,
  output logic [CNT_W-1:0]       rspCount
);
  logic        pktEnd;
  pktKind_e    pktKind;
  ctrlStrobe_t str;

  ptrk_ctrl #(.STALE_W(2)) ctrl (
    .clk(clk), .rstN(rstN), .pktEnd(pktEnd), .pktKind(pktKind),
    .reqReady(reqReady), .cplValid(cplValid), .reqValid(reqValid), .str(str)
  );

  ptrk_datapath #(.MAX_PARAM(MAX_PARAM), .MAX_DATA(MAX_DATA), .CNT_W(CNT_W)) dp (
    .clk(clk), .rstN(rstN), .wrValid(wrValid), .wrByte(wrByte), .wrLast(wrLast),
    .pktEnd(pktEnd), .pktKind(pktKind), .str(str), .cplErr(cplErr), .cplCode(cplCode),
    .cplLen(cplLen), .cplData(cplData), .reqOp(reqOp), .reqParam(reqParam),
    .rdIdx(rdIdx), .rdByte(rdByte), .rspCount(rspCount)
  );

  assert_busy_count_R2: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |-> (rspCount == CNT_W'(1)));
endmodule

// File: tb/proxy_tracker_test.sv
`timescale 1ns/1ps
module proxy_tracker_test;
  localparam int NP = 4;
  localparam int ND = 8;
  localparam int CW = $clog2(ND + 2);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrValid = 1'b0, wrLast = 1'b0;
  logic [7:0] wrByte = '0;
  logic reqValid, reqReady = 1'b0;
  logic [7:0] reqOp;
  logic [NP*8-1:0] reqParam;
  logic cplValid = 1'b0, cplErr = 1'b0;
  logic [7:0] cplCode = '0;
  logic [CW-1:0] cplLen = '0;
  logic [ND*8-1:0] cplData = '0;
  logic [CW-1:0] rdIdx = '0;
  logic [7:0] rdByte;
  logic [CW-1:0] rspCount;

  int vectors = 0, misses = 0;
  string scen = "R10";

  always #5 clk = ~clk;

  proxy_tracker #(.MAX_PARAM(NP), .MAX_DATA(ND)) uut (
    .clk(clk), .rstN(rstN), .wrValid(wrValid), .wrByte(wrByte), .wrLast(wrLast),
    .reqValid(reqValid), .reqReady(reqReady), .reqOp(reqOp), .reqParam(reqParam),
    .cplValid(cplValid), .cplErr(cplErr), .cplCode(cplCode), .cplLen(cplLen),
    .cplData(cplData), .rdIdx(rdIdx), .rdByte(rdByte), .rspCount(rspCount)
  );

  // reference model: 0 none, 1 busy, 2 err, 3 ok ; phase 0 idle, 1 req, 2 wait
  int mKind = 0, mPhase = 0, mStale = 0, mLen = 2;
  logic [7:0] mCode = 0, mOp = 0;
  logic [NP*8-1:0] mParam = '0;
  logic [7:0] mData [ND];
  logic [7:0] pkt [$];

  task automatic modelStep();
    bit curC, staleC, ended, inc;
    int oldPh, n;
    logic [7:0] op;
    curC = cplValid && mStale == 0 && mPhase == 2;
    staleC = cplValid && mStale > 0;
    ended = 0; op = 0; n = 0; oldPh = mPhase;
    if (wrValid) begin
      pkt.push_back(wrByte);
      if (wrLast) begin
        ended = 1; op = pkt[0]; n = pkt.size() - 1;
      end
    end
    if (staleC) mStale--;
    if (ended && op == 8'h0F) begin
      inc = (oldPh == 2 && !curC) || (oldPh == 1 && reqReady);
      if (inc && mStale < 3) mStale++;
      mPhase = 0; mKind = 0; mCode = 0;
    end else begin
      if (oldPh == 1 && reqReady) mPhase = 2;
      else if (curC) begin
        mPhase = 0;
        if (cplErr) begin mKind = 2; mCode = cplCode; end
        else begin
          int l = (int'(cplLen) > ND) ? ND : int'(cplLen);
          mKind = 3; mLen = (l < 2) ? 2 : l;
          for (int i = 0; i < ND; i++) mData[i] = (i < l) ? cplData[8*i +: 8] : 8'h00;
        end
      end
      if (ended && oldPh == 0) begin
        int want = (op == 8'h01) ? 0 : (op == 8'h02) ? 2 : (op == 8'h03) ? 3 : -1;
        if (want < 0) begin mKind = 2; mCode = 8'h01; end
        else if (n != want) begin mKind = 2; mCode = 8'h02; end
        else if (op == 8'h01) begin
          mKind = 3; mLen = 2;
          for (int i = 0; i < ND; i++) mData[i] = 8'h00;
        end else begin
          mKind = 1; mPhase = 1; mOp = op; mParam = '0;
          for (int i = 0; i < n; i++) mParam[8*i +: 8] = pkt[i+1];
        end
      end
    end
    if (ended) pkt.delete();
  endtask

  function automatic int expCount();
    return (mKind == 1) ? 1 : (mKind == 3) ? 1 + mLen : 2;
  endfunction

  function automatic int expByte(int idx);
    if (idx >= expCount()) return 0;
    if (idx == 0) return (mKind == 1) ? 1 : (mKind == 3) ? 0 : 2;
    if (mKind == 3) return int'(mData[idx-1]);
    return int'(mCode);
  endfunction

  function automatic string kindTag();
    return (mKind == 1) ? "R2" : (mKind == 2) ? "R3" : (mKind == 3) ? "R4" : "R10";
  endfunction

  task automatic check(bit ok, string tag, longint act, longint exp);
    vectors++;
    if (!ok) begin
      misses++;
      $display("FAIL %s/%s at %0t: got %0h expected %0h", scen, tag, $time, act, exp);
    end
  endtask

  task automatic compareAll();
    int i = int'(rdIdx);
    check(int'(rspCount) == expCount(), kindTag(), rspCount, expCount());
    check(int'(rdByte) == expByte(i), (i == 0) ? "R1" : kindTag(), rdByte, expByte(i));
    check(reqValid == (mPhase == 1), "R6", reqValid, mPhase == 1);
    check(reqOp == mOp && reqParam == mParam, "R6", {reqOp, reqParam}, {mOp, mParam});
  endtask

  task automatic tick();
    @(posedge clk);
    if (rstN) modelStep();
    @(negedge clk);
    compareAll();
    rdIdx = rdIdx + 1'b1;
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) tick();
  endtask

  task automatic sendPkt(int n, logic [63:0] b, int gap);
    for (int k = 0; k < n; k++) begin
      wrValid = 1; wrByte = b[8*k +: 8]; wrLast = (k == n - 1);
      tick();
      wrValid = 0; wrLast = 0;
      if (gap > 0 && k != n - 1) idle(gap);
    end
  endtask

  task automatic complete(bit err, logic [7:0] code, int len, logic [63:0] data);
    cplValid = 1; cplErr = err; cplCode = code; cplLen = CW'(len); cplData = data;
    tick();
    cplValid = 0; cplErr = 0;
  endtask

  initial begin
    #2_000_000;
    misses++;
    $display("FAIL watchdog: run did not finish");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    for (int i = 0; i < ND; i++) mData[i] = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
    // reset state R10
    rdIdx = 0; #1;
    check(rspCount == 2 && rdByte == 8'h02, "R10", {rspCount, rdByte}, {4'd2, 8'h02});
    idle(10);
    scen = "R5"; sendPkt(1, 64'h01, 0); idle(10);
    sendPkt(2, 64'h0055, 0); idle(6);
    rdIdx = 1; #1;
    check(rspCount == 2 && rdByte == 8'h01, "R5", {rspCount, rdByte}, {4'd2, 8'h01});
    sendPkt(2, 64'h1102, 0); idle(6);
    sendPkt(7, 64'h06_05_04_03_02_01_03, 0); idle(6);
    rdIdx = 1; #1;
    check(rspCount == 2 && rdByte == 8'h02, "R5", {rspCount, rdByte}, {4'd2, 8'h02});
    // forward read, hold off ready, drop during busy
    scen = "R6"; sendPkt(3, 64'hBB_AA_02, 0); idle(3);
    check(reqValid == 1 && rspCount == 1, "R2", {reqValid, rspCount}, {1'b1, 4'd1});
    reqReady = 1; tick(); reqReady = 0; idle(2);
    scen = "R7"; sendPkt(4, 64'h03_02_01_03, 0); sendPkt(1, 64'h01, 0); idle(2);
    scen = "R4"; complete(0, 0, 5, 64'h0000_0055_4433_2211); idle(12);
    scen = "R4"; sendPkt(4, 64'h09_08_07_03, 0); reqReady = 1; tick(); reqReady = 0;
    complete(0, 0, 0, 64'hFFFF); idle(6);
    sendPkt(3, 64'h22_11_02, 0); reqReady = 1; idle(2); reqReady = 0;
    complete(0, 0, 12, 64'h8877_6655_4433_2211); idle(12);
    rdIdx = 8; #1;
    check(rspCount == 9 && rdByte == 8'h88, "R4", {rspCount, rdByte}, {4'd9, 8'h88});
    scen = "R3"; sendPkt(3, 64'h34_12_02, 0); reqReady = 1; tick(); reqReady = 0;
    complete(1, 8'h33, 0, 0); idle(6);
    // clear while waiting, then the orphaned completion
    scen = "R8"; sendPkt(3, 64'h34_12_02, 0); reqReady = 1; tick(); reqReady = 0;
    sendPkt(1, 64'h0F, 0); idle(2);
    scen = "R9"; sendPkt(3, 64'h66_55_02, 0); reqReady = 1; tick(); reqReady = 0;
    complete(0, 0, 3, 64'hDEAD); idle(3);
    complete(0, 0, 3, 64'h03_02_01); idle(10);
    // clear during unaccepted request; spurious completion
    scen = "R8"; sendPkt(4, 64'h77_66_55_03, 0); idle(2); sendPkt(3, 64'h99_98_0F, 0); idle(2);
    scen = "R9"; complete(0, 0, 4, 64'hABCD); idle(4);
    // clear accepted in same cycle as handshake
    scen = "R8"; sendPkt(3, 64'h44_33_02, 0); reqReady = 1; sendPkt(1, 64'h0F, 0); reqReady = 0;
    scen = "R9"; complete(1, 8'h77, 0, 0); idle(4);
    // framing with idle gaps
    scen = "R11"; sendPkt(3, 64'hC2_C1_02, 3); idle(2); reqReady = 1; tick(); reqReady = 0;
    complete(0, 0, 2, 64'h5A_A5); idle(10);
    sendPkt(1, 64'h01, 2); idle(4);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule